// File: doc/BRIEF.md
# DDS Quadrature Modulator Datapath

This block is the digital core of a numerically controlled oscillator that can modulate frequency, phase and amplitude. A 32-bit phase accumulator advances on every clock by one of two frequency tuning words. A select line picks the word separately on each cycle, so frequency-shift keying costs nothing beyond toggling that line. A 12-bit phase offset is added to the top of the accumulator, and the resulting phase addresses a sine and a cosine waveform. When amplitude modulation is on, each waveform is scaled by its own signed gain taken from a 20-bit IQ word. The two scaled values are combined into one signed 10-bit output code. This is the form needed for quadrature amplitude and single-sideband generation.

All control inputs come from a register or control block one level up, and they are sampled on the same clock edge. Each one is delayed inside the block so that it reaches its own pipeline stage together with the data from that edge. A change of frequency, phase, gain or mode therefore shows at the output on one known cycle, with no partial mixing. A valid strobe tells the consumer when the pipeline holds only data captured after reset. Synchronous, active-high reset clears all state.

Top module: `dds_iq_modulator`

## Requirements
- R1: On every clock the accumulator adds `freq_a` when `freq_pick` is 0, or `freq_b` when `freq_pick` is 1. The choice is made anew on each cycle, and the sum wraps modulo 2^32.
- R2: The waveform phase is accumulator bits 31:20 plus `phase_ofs`, modulo 4096.
- R3: For phase p in [0,2048), the sine value is floor(511*16*p*(2048-p) / (5*2048*2048 - 4*p*(2048-p))). For p in [2048,4096) it is minus the value at p-2048. The cosine at p is the sine at (p+1024) mod 4096. Both are signed 10-bit values in [-511,511].
- R4: With `am_on` = 1, `iq_gain[19:10]` (two's complement) is the sine gain G and `iq_gain[9:0]` (two's complement) is the cosine gain H. The output is floor((floor(S*G/512) + floor(C*H/512)) / 2), where S is the sine and C the cosine.
- R5: With `am_on` = 0, the output equals the sine value, and `iq_gain` has no effect.
- R6: When `acc_zero` is 1, the accumulator becomes 0 on that cycle and the frequency word of that cycle is discarded.
- R7: All inputs sampled at clock edge k act together on the output that appears after edge k+6.
- R8: `wave_vld` is 0 during reset and for six edges after reset is released. It rises after the seventh edge following release and stays high until the next reset.
- R9: While reset is asserted, `wave_out` is 0.
- R10: `wave_out` never takes the code -512 (10'h200).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| freq_a | input | 32 | Tuning word used when `freq_pick` is 0 |
| freq_b | input | 32 | Tuning word used when `freq_pick` is 1 |
| freq_pick | input | 1 | Per-cycle tuning word select |
| acc_zero | input | 1 | Clears the phase accumulator |
| phase_ofs | input | 12 | Phase offset added to the accumulator's top bits |
| iq_gain | input | 20 | Sine gain in [19:10], cosine gain in [9:0], two's complement |
| am_on | input | 1 | Enables the IQ gain and sum stage |
| wave_out | output | 10 | Signed output code |
| wave_vld | output | 1 | Output holds post-reset data |

## Verification
A slow sweep of one phase step per cycle visits every table address, including the quadrant edges at 1023, 1024, 2047 and 2048. At those addresses a wrong fold index or a misplaced sign would give a spike or a sign flip. Gains of -512, 511, -1 and 0 on negative table values check the floor rounding of the products and of the halving; a design that truncates toward zero is one LSB off there. A select line that toggles every cycle catches a mux that is registered one cycle too late. Random clear pulses catch a clear that still adds the current word. Mode, offset and gain all change on the same cycle, so a wrong delay on any one path makes the output disagree with a model that applies every input of a cycle together. The valid edge is checked both after the first reset and after a reset in the middle of the run.

// File: rtl/dds_pkg.sv
package dds_pkg;

  // Quadrant of a waveform phase, taken from its two top bits
  typedef enum logic [1:0] {
    Q_RISE  = 2'd0,
    Q_FALL  = 2'd1,
    Q_DIP   = 2'd2,
    Q_CLIMB = 2'd3
  } quad_e;

  // Rational sine-shaped magnitude over a half period of 2^(ph_w-1) steps
  function automatic longint shape_val(longint t, int ph_w, int amp_w);
    longint half;
    longint amp;
    longint u;
    longint num;
    longint den;
    half = longint'(1) << (ph_w - 1);
    amp  = (longint'(1) << (amp_w - 1)) - 1;
    u    = t * (half - t);
    num  = amp * 16 * u;
    den  = 5 * half * half - 4 * u;
    return num / den;
  endfunction

  // Product scaling and halving: each product keeps its top bits, floor rounding
  function automatic int mix_combine(int ps, int pc, int amp_w);
    int a;
    int b;
    a = ps >>> (amp_w - 1);
    b = pc >>> (amp_w - 1);
    return (a + b) >>> 1;
  endfunction

endpackage

// File: rtl/dds_delay.sv
module dds_delay #(
  parameter int W = 1,
  parameter int D = 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);

  if (D == 0) begin : g_wire
    assign dout = din;
  end else begin : g_pipe
    logic [W-1:0] stg [D];
    always_ff @(posedge clk) begin
      if (rst) begin
        for (int i = 0; i < D; i++) stg[i] <= '0;
      end else begin
        stg[0] <= din;
        for (int i = 1; i < D; i++) stg[i] <= stg[i-1];
      end
    end
    assign dout = stg[D-1];
  end

endmodule

// File: rtl/dds_phase_gen.sv
module dds_phase_gen #(
  parameter int ACC_W = 32,
  parameter int PH_W  = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [ACC_W-1:0] word_a,
  input  logic [ACC_W-1:0] word_b,
  input  logic             pick,
  input  logic             clear,
  input  logic [PH_W-1:0]  ofs,
  output logic [PH_W-1:0]  phase
);

  // offset must meet the accumulator value from the same input edge
  localparam int OFS_DLY = 2;

  logic [ACC_W-1:0] inc_q;
  logic             clr_q;
  logic [ACC_W-1:0] acc_q;
  logic [PH_W-1:0]  pofs_d;
  logic [PH_W-1:0]  phase_q;

  dds_delay #(.W(PH_W), .D(OFS_DLY)) u_ofs_dly (
    .clk  (clk),
    .rst  (rst),
    .din  (ofs),
    .dout (pofs_d)
  );

  // stage 1: per-cycle word select
  always_ff @(posedge clk) begin
    if (rst) begin
      inc_q <= '0;
      clr_q <= 1'b0;
    end else begin
      inc_q <= pick ? word_b : word_a;
      clr_q <= clear;
    end
  end

  // stage 2: accumulate, clear discards the pending increment
  always_ff @(posedge clk) begin
    if (rst)        acc_q <= '0;
    else if (clr_q) acc_q <= '0;
    else            acc_q <= acc_q + inc_q;
  end

  // stage 3: phase offset, modulo 2^PH_W
  always_ff @(posedge clk) begin
    if (rst) phase_q <= '0;
    else     phase_q <= acc_q[ACC_W-1 -: PH_W] + pofs_d;
  end

  assign phase = phase_q;

  // R6: after a clear the phase carries only the offset
  a_r6_clear_phase: assert property (@(posedge clk) disable iff (rst)
    clr_q |=> ##1 (phase_q == $past(pofs_d)));

  // lower accumulator bits feed only the carry chain
  logic unused_low;
  assign unused_low = ^acc_q[ACC_W-PH_W-1:0];

endmodule

// File: rtl/dds_wave_rom.sv
module dds_wave_rom
  import dds_pkg::*;
#(
  parameter int PH_W  = 12,
  parameter int AMP_W = 10
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [PH_W-1:0]         phase,
  output logic signed [AMP_W-1:0] sin_o,
  output logic signed [AMP_W-1:0] cos_o
);

  localparam int QW       = PH_W - 2;
  localparam int QFULL    = 1 << QW;
  localparam int QN       = QFULL + 1;
  localparam int MW       = AMP_W - 1;
  localparam int AMP_MAX  = (1 << MW) - 1;

  // quarter-wave magnitude table, both ends included
  logic [MW-1:0] rom [QN];
  for (genvar g = 0; g < QN; g++) begin : g_rom
    assign rom[g] = MW'(shape_val(longint'(g), PH_W, AMP_W));
  end

  logic [PH_W-1:0]         lane_ph  [2];
  logic signed [AMP_W-1:0] lane_out [2];
  logic [MW-1:0]           lane_mag [2];

  assign lane_ph[0] = phase;
  assign lane_ph[1] = phase + PH_W'(QFULL);

  for (genvar l = 0; l < 2; l++) begin : g_lane
    quad_e                   quad;
    logic [QW-1:0]           idx;
    logic [QW:0]             addr;
    logic                    neg;
    logic                    neg_q;
    logic [MW-1:0]           mag_q;
    logic signed [AMP_W-1:0] val_q;

    always_comb begin
      quad = quad_e'(lane_ph[l][PH_W-1 -: 2]);
      idx  = lane_ph[l][QW-1:0];
      if (quad == Q_FALL || quad == Q_CLIMB) addr = (QW+1)'(QFULL) - {1'b0, idx};
      else                                   addr = {1'b0, idx};
      neg  = (quad == Q_DIP || quad == Q_CLIMB);
    end

    // stage 4: table read, stage 5: sign restore
    always_ff @(posedge clk) begin
      if (rst) begin
        mag_q <= '0;
        neg_q <= 1'b0;
        val_q <= '0;
      end else begin
        mag_q <= rom[addr];
        neg_q <= neg;
        val_q <= neg_q ? -$signed({1'b0, mag_q}) : $signed({1'b0, mag_q});
      end
    end

    assign lane_out[l] = val_q;
    assign lane_mag[l] = mag_q;
  end

  assign sin_o = lane_out[0];
  assign cos_o = lane_out[1];

  logic [MW-1:0] sin_mag;
  logic [MW-1:0] cos_mag;
  assign sin_mag = lane_mag[0];
  assign cos_mag = lane_mag[1];

  // R3: phase zero reads sine zero and cosine peak
  a_r3_zero_phase: assert property (@(posedge clk) disable iff (rst)
    (phase == '0) |=> (sin_mag == '0 && cos_mag == MW'(AMP_MAX)));

endmodule

// File: rtl/dds_iq_mixer.sv
module dds_iq_mixer
  import dds_pkg::*;
#(
  parameter int AMP_W = 10
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic signed [AMP_W-1:0] sin_i,
  input  logic signed [AMP_W-1:0] cos_i,
  input  logic [2*AMP_W-1:0]      gain,
  input  logic                    am_en,
  output logic [AMP_W-1:0]        mix_o
);

  localparam int PW = 2 * AMP_W;

  logic signed [AMP_W-1:0] gain_s;
  logic signed [AMP_W-1:0] gain_c;
  logic signed [PW-1:0]    sin_x;
  logic signed [PW-1:0]    cos_x;
  logic signed [PW-1:0]    gs_x;
  logic signed [PW-1:0]    gc_x;

  assign gain_s = gain[PW-1:AMP_W];
  assign gain_c = gain[AMP_W-1:0];
  assign sin_x  = $signed({{AMP_W{sin_i[AMP_W-1]}}, sin_i});
  assign cos_x  = $signed({{AMP_W{cos_i[AMP_W-1]}}, cos_i});
  assign gs_x   = $signed({{AMP_W{gain_s[AMP_W-1]}}, gain_s});
  assign gc_x   = $signed({{AMP_W{gain_c[AMP_W-1]}}, gain_c});

  logic signed [PW-1:0]    prod_s_q;
  logic signed [PW-1:0]    prod_c_q;
  logic                    am_q;
  logic signed [AMP_W-1:0] pass_q;
  logic [AMP_W-1:0]        out_q;

  // stage 6: gains applied
  always_ff @(posedge clk) begin
    if (rst) begin
      prod_s_q <= '0;
      prod_c_q <= '0;
      am_q     <= 1'b0;
      pass_q   <= '0;
    end else begin
      prod_s_q <= sin_x * gs_x;
      prod_c_q <= cos_x * gc_x;
      am_q     <= am_en;
      pass_q   <= sin_i;
    end
  end

  // stage 7: combine or bypass
  always_ff @(posedge clk) begin
    if (rst)       out_q <= '0;
    else if (am_q) out_q <= AMP_W'(mix_combine(int'(prod_s_q), int'(prod_c_q), AMP_W));
    else           out_q <= pass_q;
  end

  assign mix_o = out_q;

  // R5: bypass hands the sine through two stages unchanged
  a_r5_bypass_sine: assert property (@(posedge clk) disable iff (rst)
    !am_en |=> ##1 (mix_o == $past(sin_i, 2)));

  // R10: the most negative code never appears
  a_r10_no_min_code: assert property (@(posedge clk) disable iff (rst)
    mix_o != {1'b1, {(AMP_W-1){1'b0}}});

endmodule

// File: rtl/dds_iq_modulator.sv
module dds_iq_modulator #(
  parameter int ACC_W = 32,
  parameter int PH_W  = 12,
  parameter int AMP_W = 10
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [ACC_W-1:0]   freq_a,
  input  logic [ACC_W-1:0]   freq_b,
  input  logic               freq_pick,
  input  logic               acc_zero,
  input  logic [PH_W-1:0]    phase_ofs,
  input  logic [2*AMP_W-1:0] iq_gain,
  input  logic               am_on,
  output logic [AMP_W-1:0]   wave_out,
  output logic               wave_vld
);

  localparam int PG_ST    = 3;
  localparam int RM_ST    = 2;
  localparam int MX_ST    = 2;
  localparam int IQ_DLY   = PG_ST + RM_ST;
  localparam int PIPE_LAT = PG_ST + RM_ST + MX_ST;
  localparam int CW       = 2 * AMP_W + 1;

  logic [PH_W-1:0]         phase;
  logic signed [AMP_W-1:0] sin_v;
  logic signed [AMP_W-1:0] cos_v;
  logic [CW-1:0]           ctl_d;

  dds_phase_gen #(.ACC_W(ACC_W), .PH_W(PH_W)) u_phase (
    .clk    (clk),
    .rst    (rst),
    .word_a (freq_a),
    .word_b (freq_b),
    .pick   (freq_pick),
    .clear  (acc_zero),
    .ofs    (phase_ofs),
    .phase  (phase)
  );

  dds_wave_rom #(.PH_W(PH_W), .AMP_W(AMP_W)) u_rom (
    .clk   (clk),
    .rst   (rst),
    .phase (phase),
    .sin_o (sin_v),
    .cos_o (cos_v)
  );

  // gain and mode travel alongside the phase path
  dds_delay #(.W(CW), .D(IQ_DLY)) u_ctl_dly (
    .clk  (clk),
    .rst  (rst),
    .din  ({am_on, iq_gain}),
    .dout (ctl_d)
  );

  dds_iq_mixer #(.AMP_W(AMP_W)) u_mix (
    .clk   (clk),
    .rst   (rst),
    .sin_i (sin_v),
    .cos_i (cos_v),
    .gain  (ctl_d[2*AMP_W-1:0]),
    .am_en (ctl_d[CW-1]),
    .mix_o (wave_out)
  );

  logic [PIPE_LAT-1:0] vld_sr;
  always_ff @(posedge clk) begin
    if (rst) vld_sr <= '0;
    else     vld_sr <= {vld_sr[PIPE_LAT-2:0], 1'b1};
  end
  assign wave_vld = vld_sr[PIPE_LAT-1];

  // R8: valid holds once raised
  a_r8_vld_holds: assert property (@(posedge clk) disable iff (rst)
    wave_vld |=> wave_vld);

endmodule

// File: tb/dds_iq_modulator_tb_top.sv
`timescale 1ns/1ps
module dds_iq_modulator_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] freq_a = '0;
  logic [31:0] freq_b = '0;
  logic        freq_pick = 1'b0;
  logic        acc_zero = 1'b0;
  logic [11:0] phase_ofs = '0;
  logic [19:0] iq_gain = '0;
  logic        am_on = 1'b0;
  logic [9:0]  wave_out;
  logic        wave_vld;

  always #2 clk = ~clk;

  dds_iq_modulator dut_i (
    .clk       (clk),
    .rst       (rst),
    .freq_a    (freq_a),
    .freq_b    (freq_b),
    .freq_pick (freq_pick),
    .acc_zero  (acc_zero),
    .phase_ofs (phase_ofs),
    .iq_gain   (iq_gain),
    .am_on     (am_on),
    .wave_out  (wave_out),
    .wave_vld  (wave_vld)
  );

  int          total = 0;
  int          bad = 0;
  string       tag = "R9";
  int          exp_q[$];
  logic [31:0] m_acc = '0;

  // half-period shape from R3
  function automatic int half_shape(int t);
    longint u;
    u = longint'(t) * longint'(2048 - t);
    return int'((longint'(511) * 16 * u) / (longint'(5) * 2048 * 2048 - 4 * u));
  endfunction

  function automatic int ref_sin(int p);
    int q;
    q = p % 4096;
    if (q < 2048) return half_shape(q);
    return -half_shape(q - 2048);
  endfunction

  function automatic int floor_div(int x, int d);
    if (x >= 0) return x / d;
    return -((-x + d - 1) / d);
  endfunction

  function automatic int pick_gain(int k);
    case (k)
      0: return -512;
      1: return 511;
      2: return 0;
      default: return -1;
    endcase
  endfunction

  task automatic chk(string t, int got, int expv);
    total++;
    if (got != expv) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", t, got, expv);
    end
  endtask

  // sets the inputs for the next edge and records the output they should give
  task automatic apply(logic [31:0] fa, logic [31:0] fb, logic sel, logic clr,
                       logic [11:0] po, logic [19:0] iq, logic am);
    int p;
    int s;
    int c;
    int g;
    int h;
    int e;
    freq_a = fa; freq_b = fb; freq_pick = sel; acc_zero = clr;
    phase_ofs = po; iq_gain = iq; am_on = am;
    if (clr) m_acc = '0;
    else     m_acc = m_acc + (sel ? fb : fa);
    p = (int'(m_acc[31:20]) + int'(po)) % 4096;
    s = ref_sin(p);
    c = ref_sin(p + 1024);
    if (am) begin
      g = int'($signed(iq[19:10]));
      h = int'($signed(iq[9:0]));
      e = floor_div(floor_div(s * g, 512) + floor_div(c * h, 512), 2);
    end else begin
      e = s;
    end
    exp_q.push_back(e);
  endtask

  task automatic drive(logic [31:0] fa, logic [31:0] fb, logic sel, logic clr,
                       logic [11:0] po, logic [19:0] iq, logic am);
    int got;
    @(negedge clk);
    got = int'($signed(wave_out));
    if (exp_q.size() == 7) begin
      chk({tag, " output (R7 alignment)"}, got, exp_q.pop_front());
      chk("R10 code -512 seen", (got == -512) ? 1 : 0, 0);
      chk("R8 valid after fill", int'(wave_vld), 1);
    end else begin
      chk("R8 valid during fill", int'(wave_vld), 0);
    end
    apply(fa, fb, sel, clr, po, iq, am);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    repeat (3) @(negedge clk);
    chk("R9 output in reset", int'(wave_out), 0);
    chk("R8 valid in reset", int'(wave_vld), 0);
    rst = 1'b0;
    exp_q.delete();
    m_acc = '0;
    apply('0, '0, 1'b0, 1'b0, '0, '0, 1'b0);
  endtask

  initial begin
    do_reset();

    tag = "R1";
    repeat (300) drive($urandom, $urandom, 1'($urandom), 1'b0, '0, '0, 1'b0);
    repeat (100) drive(32'h0123_4567, 32'h7654_3210, 1'b1, 1'b0, '0, '0, 1'b0);

    tag = "R2";
    repeat (300) drive($urandom, $urandom, 1'($urandom), 1'b0, 12'($urandom), '0, 1'b0);

    tag = "R3 sine sweep";
    repeat (4200) drive(32'h0010_0000, '0, 1'b0, 1'b0, '0, '0, 1'b0);

    tag = "R3 R4 cosine sweep";
    repeat (4200) drive(32'h0010_0000, '0, 1'b0, 1'b0, '0, {10'd0, 10'h200}, 1'b1);

    tag = "R4 R7";
    repeat (600) drive($urandom, $urandom, 1'($urandom), 1'b0, 12'($urandom), 20'($urandom), 1'b1);

    tag = "R4 extreme gains";
    repeat (300) drive($urandom, $urandom, 1'($urandom), 1'b0, 12'($urandom),
                       {10'(pick_gain(int'($urandom_range(0, 3)))), 10'(pick_gain(int'($urandom_range(0, 3))))}, 1'b1);

    tag = "R5";
    repeat (300) drive($urandom, $urandom, 1'($urandom), 1'b0, 12'($urandom), 20'($urandom), 1'b0);

    tag = "R6";
    repeat (400) drive($urandom, $urandom, 1'($urandom), ($urandom_range(0, 7) == 0),
                       12'($urandom), 20'($urandom), 1'($urandom));

    tag = "R5 R7 mode toggling";
    repeat (300) drive($urandom, $urandom, 1'($urandom), 1'b0, 12'($urandom), 20'($urandom), 1'($urandom));

    do_reset();
    tag = "R8 R9 after mid-run reset";
    repeat (200) drive($urandom, $urandom, 1'($urandom), 1'b0, 12'($urandom), 20'($urandom), 1'b1);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog R7 actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule